// File: doc/BRIEF.md
# Sector write serializer

This block sends one preformatted sector from the controller's buffer memory to the drive as a serial bit stream. Firmware first lays out the sector image in the buffer, starting at a fixed base address: the zero preamble, the sync bytes, the header and the data. It then pulses a start command. The block arms itself and reports busy. It waits for the drive's next sector pulse, and that pulse opens the write window. The block raises the write gate, takes ownership of the buffer and clears its check-code register. It then reads the image byte by byte and shifts each byte out MSB first, one bit per drive clock.

When the last image byte has gone out, the block appends a 32-bit check code computed over the image. It then sends zeros until the following sector pulse. That pulse closes the window, returns the buffer and clears busy. The whole block runs on the drive clock. The start and sector-pulse inputs are expected to arrive already synchronised to that clock as one-cycle pulses. The buffer is a synchronous RAM: data comes back one cycle after the address.

Top module: `sector_write_serializer`

## Requirements
- R1: After reset, wr_gate, buf_grant, wr_busy, wr_data and buf_rd_en are all 0.
- R2: A cmd_start pulse while idle sets wr_busy in the next cycle. wr_busy stays 1 while a write is armed or in progress, and falls in the same cycle as wr_gate.
- R3: A sector_pulse while the block is not armed has no effect: wr_gate and buf_grant stay 0.
- R4: The first sector_pulse after a start raises wr_gate and buf_grant in the next cycle and clears the check code to zero. buf_grant equals wr_gate in every cycle.
- R5: During a window the block reads exactly PAYLOAD_BYTES bytes from addresses BASE_ADDR, BASE_ADDR+1, and so on in rising order. Reads are spaced 8 cycles apart, the first is in the first cycle of the window, and buf_rd_en is never 1 without buf_grant.
- R6: The serial stream starts with two zero lead bits in the first two gate cycles. After that, each image byte is sent MSB first, one bit per clock, with no gaps.
- R7: Directly after the image comes a 32-bit code, sent MSB first. The code is a CRC with polynomial 0x04C11DB7, initial value 0, no bit reflection and no final inversion, taken over the image bits in the order they were sent.
- R8: After the code, wr_data is 0 until the window closes. wr_data is 0 in every cycle in which wr_gate is 0.
- R9: A sector_pulse while wr_gate is 1 drops wr_gate and buf_grant in the next cycle, even in the middle of the image or the code.
- R10: A cmd_start while wr_busy is 1 is ignored. The running stream is not disturbed, and no new write is armed after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock, one bit time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle start command from the controller CPU |
| wr_busy | output | 1 | Write armed or in progress |
| sector_pulse | input | 1 | One-cycle sector mark from the drive |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_addr | output | ADDR_W | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, valid one cycle after the strobe |
| buf_grant | output | 1 | Buffer owned by this block |
| wr_gate | output | 1 | Drive write enable |
| wr_data | output | 1 | Serial write data |

## Verification
The bench goes after the edges of the write window. It closes the window one bit after the code ends, exactly on the final code bit, and partway through the image. A design that counts the window from the start command instead of from the sector pulse, or that holds the gate until the sector is complete, would show a shifted or overlong gate. Each vector's stream is compared bit by bit against a CRC computed in the bench. A wrong bit order, a missed clear of the code register, or a code that also covers the lead bits would corrupt the final 32 bits. A start issued during a write is checked both for leaving the stream intact and for not re-arming the block. A sector pulse while idle and a reset in the middle of a write are also exercised.

// File: rtl/swr_pkg.sv
// Shared definitions for the sector write serializer.
// Assumes: a byte-wide buffer and a 32-bit check code.
package swr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_DATA,
        PH_CODE,
        PH_GAP
    } swr_phase_e;

    localparam int unsigned CODE_BYTES = 4;
    localparam int unsigned CODE_W     = 8 * CODE_BYTES;
    localparam logic [2:0]  BIT_FETCH  = 3'd6;
    localparam logic [2:0]  BIT_LAST   = 3'd7;
endpackage

// File: rtl/swr_sequencer.sv
// Window and byte sequencer: arms on start, opens and closes the write
// window on sector pulses, keeps the bit and byte position and issues
// buffer reads early enough for a one-cycle-latency RAM.
// Assumes: start and sector pulse are one-cycle pulses in the clk domain.
module swr_sequencer
    import swr_pkg::*;
#(
    parameter int unsigned ADDR_W        = 14,
    parameter int unsigned BASE_ADDR     = 0,
    parameter int unsigned PAYLOAD_BYTES = 1046
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sector_pulse_i,
    output logic              busy_o,
    output logic              gate_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              open_o,
    output logic              load_o,
    output logic              load_payload_o,
    output logic              feed_o,
    output logic              code_o
);
    localparam int unsigned IDX_W = ($clog2(PAYLOAD_BYTES) > 2) ? $clog2(PAYLOAD_BYTES) : 2;
    localparam logic [IDX_W-1:0]  LAST_PAY  = IDX_W'(PAYLOAD_BYTES - 1);
    localparam logic [IDX_W-1:0]  LAST_CODE = IDX_W'(CODE_BYTES - 1);
    localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_ADDR);

    swr_phase_e        phase_q;
    logic [2:0]        bit_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              busy_q;
    logic              gate_q;
    logic              close_w;
    logic              more_pay_w;
    logic              byte_end_w;

    // Window edge events and next-byte source.
    always_comb begin
        open_o     = busy_q && !gate_q && sector_pulse_i;
        close_w    = gate_q && sector_pulse_i;
        more_pay_w = (phase_q == PH_LEAD) || ((phase_q == PH_DATA) && (idx_q != LAST_PAY));
        byte_end_w = gate_q && (bit_q == BIT_LAST);
    end

    // Strobes towards the buffer, the shifter and the code generator.
    always_comb begin
        rd_en_o        = gate_q && (bit_q == BIT_FETCH) && more_pay_w;
        rd_addr_o      = addr_q;
        load_o         = byte_end_w;
        load_payload_o = more_pay_w;
        feed_o         = gate_q && (phase_q == PH_DATA);
        code_o         = gate_q && (phase_q == PH_CODE);
        busy_o         = busy_q;
        gate_o         = gate_q;
    end

    // Busy flag: set by an accepted start, cleared when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= 1'b0;
        else if (close_w)            busy_q <= 1'b0;
        else if (start_i && !busy_q) busy_q <= 1'b1;
    end

    // Write gate: opened and closed by sector pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= 1'b0;
        else if (open_o)  gate_q <= 1'b1;
        else if (close_w) gate_q <= 1'b0;
    end

    // Bit counter: free running, realigned so two lead bits precede byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_q <= 3'd0;
        else if (open_o) bit_q <= BIT_FETCH;
        else             bit_q <= bit_q + 3'd1;
    end

    // Buffer address: restarts at the base, advances per read.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= BASE;
        else if (open_o)  addr_q <= BASE;
        else if (rd_en_o) addr_q <= addr_q + ADDR_W'(1);
    end

    // Phase and byte index: lead, image, code, zero gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (open_o) begin
            phase_q <= PH_LEAD;
            idx_q   <= '0;
        end else if (close_w) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (byte_end_w) begin
            unique case (phase_q)
                PH_LEAD: begin
                    phase_q <= PH_DATA;
                    idx_q   <= '0;
                end
                PH_DATA: begin
                    if (idx_q == LAST_PAY) begin
                        phase_q <= PH_CODE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_CODE: begin
                    if (idx_q == LAST_CODE) phase_q <= PH_GAP;
                    else                    idx_q   <= idx_q + IDX_W'(1);
                end
                default: phase_q <= phase_q;
            endcase
        end
    end
endmodule

// File: rtl/swr_shifter.sv
// Byte shift register: takes a byte from the buffer (or zero once the
// image is exhausted) at each byte boundary and presents it MSB first.
// Assumes: load and shift strobes come from the sequencer.
module swr_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       load_i,
    input  logic       load_payload_i,
    input  logic       shift_i,
    input  logic [7:0] rd_data_i,
    output logic       bit_o
);
    logic [7:0] sh_q;

    // Shift register: clear on open, load at a byte end, else shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= 8'h00;
        else if (clear_i) sh_q <= 8'h00;
        else if (load_i)  sh_q <= load_payload_i ? rd_data_i : 8'h00;
        else if (shift_i) sh_q <= {sh_q[6:0], 1'b0};
    end

    // Current serial bit.
    always_comb bit_o = sh_q[7];
endmodule

// File: rtl/swr_crc.sv
// Serial check-code generator: accumulates a CRC over the outgoing image
// bits, then shifts the result out MSB first.
// Assumes: feed and shift are never active together.
module swr_crc #(
    parameter int unsigned CODE_W = 32,
    parameter logic [CODE_W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic feed_i,
    input  logic shift_i,
    input  logic din_i,
    output logic code_bit_o
);
    logic [CODE_W-1:0] crc_q;
    logic              fb_w;

    // Feedback bit of the division.
    always_comb fb_w = crc_q[CODE_W-1] ^ din_i;

    // Code register: clear, accumulate a bit, or shift out.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= '0;
        else if (clear_i) crc_q <= '0;
        else if (feed_i)  crc_q <= {crc_q[CODE_W-2:0], 1'b0} ^ (fb_w ? POLY : '0);
        else if (shift_i) crc_q <= {crc_q[CODE_W-2:0], 1'b0};
    end

    // Most significant code bit goes out first.
    always_comb code_bit_o = crc_q[CODE_W-1];
endmodule

// File: rtl/sector_write_serializer.sv
// Top of the sector write serializer: ties the sequencer, byte shifter
// and check-code generator together and forms the drive outputs.
// Assumes: everything runs on the drive clock; the buffer read has one
// cycle of latency.
module sector_write_serializer
    import swr_pkg::*;
#(
    parameter int unsigned ADDR_W        = 14,
    parameter int unsigned BASE_ADDR     = 0,
    parameter int unsigned PAYLOAD_BYTES = 1046,
    parameter logic [31:0] CRC_POLY      = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    output logic              wr_busy,
    input  logic              sector_pulse,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              buf_grant,
    output logic              wr_gate,
    output logic              wr_data
);
    logic gate_w, open_w, load_w, load_pay_w, feed_w, code_w;
    logic sh_bit_w, code_bit_w;

    swr_sequencer #(
        .ADDR_W        (ADDR_W),
        .BASE_ADDR     (BASE_ADDR),
        .PAYLOAD_BYTES (PAYLOAD_BYTES)
    ) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (cmd_start),
        .sector_pulse_i (sector_pulse),
        .busy_o         (wr_busy),
        .gate_o         (gate_w),
        .rd_en_o        (buf_rd_en),
        .rd_addr_o      (buf_rd_addr),
        .open_o         (open_w),
        .load_o         (load_w),
        .load_payload_o (load_pay_w),
        .feed_o         (feed_w),
        .code_o         (code_w)
    );

    swr_shifter i_shift (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (open_w),
        .load_i         (load_w),
        .load_payload_i (load_pay_w),
        .shift_i        (gate_w),
        .rd_data_i      (buf_rd_data),
        .bit_o          (sh_bit_w)
    );

    swr_crc #(
        .CODE_W (CODE_W),
        .POLY   (CRC_POLY)
    ) i_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (open_w),
        .feed_i     (feed_w),
        .shift_i    (code_w),
        .din_i      (sh_bit_w),
        .code_bit_o (code_bit_w)
    );

    // Drive outputs: gate, buffer ownership and the selected serial bit.
    always_comb begin
        wr_gate   = gate_w;
        buf_grant = gate_w;
        wr_data   = gate_w & (code_w ? code_bit_w : sh_bit_w);
    end
endmodule

// File: rtl/sector_write_serializer_chk.sv
// Property checker for the sector write serializer, bound to the top.
module sector_write_serializer_chk #(
    parameter int unsigned ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              wr_busy,
    input logic              sector_pulse,
    input logic              buf_rd_en,
    input logic [ADDR_W-1:0] buf_rd_addr,
    input logic              buf_grant,
    input logic              wr_gate,
    input logic              wr_data
);
    p_gate_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate |-> wr_busy);

    p_idle_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_busy && !cmd_start) |=> !wr_gate);

    p_open_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate) |-> $past(sector_pulse));

    p_read_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> buf_grant);

    p_read_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> !buf_rd_en);

    p_read_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en && wr_gate && !sector_pulse) |=> (buf_rd_addr == $past(buf_rd_addr) + ADDR_W'(1)));

    p_quiet_when_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate |-> !wr_data);

    p_close_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && sector_pulse) |=> (!wr_gate && !buf_grant));
endmodule

bind sector_write_serializer sector_write_serializer_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .wr_busy      (wr_busy),
    .sector_pulse (sector_pulse),
    .buf_rd_en    (buf_rd_en),
    .buf_rd_addr  (buf_rd_addr),
    .buf_grant    (buf_grant),
    .wr_gate      (wr_gate),
    .wr_data      (wr_data)
);

// File: tb/test_sector_write_serializer.sv
`timescale 1ns/1ps
module test_sector_write_serializer;
    localparam int unsigned AW   = 12;
    localparam int unsigned BASE = 12'h100;
    localparam int unsigned NPAY = 5;
    localparam int unsigned NTOT = NPAY + 4;
    localparam int unsigned SLEN = 2 + 8 * NTOT;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;

    // Vector fields: [20:13] fill seed, [12:1] cycles until closing pulse, [0] start mid-write.
    localparam logic [20:0] VECS [0:4] = '{
        {8'h3C, 12'd90,  1'b0},
        {8'hA5, 12'd90,  1'b1},
        {8'h00, 12'd74,  1'b0},
        {8'hFF, 12'd30,  1'b0},
        {8'h5A, 12'd73,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic          sector_pulse = 1'b0;
    logic          wr_busy, buf_rd_en, buf_grant, wr_gate, wr_data;
    logic [AW-1:0] buf_rd_addr;
    logic [7:0]    buf_rd_data = 8'h00;
    logic [7:0]    mem [0:255];
    logic [AW-1:0] rd_log [0:15];
    int            rd_cnt = 0;
    logic          rd_clr = 1'b0;
    int            n_checks = 0;
    int            n_fail = 0;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    sector_write_serializer #(
        .ADDR_W(AW), .BASE_ADDR(BASE), .PAYLOAD_BYTES(NPAY), .CRC_POLY(POLY)
    ) i_sector_write_serializer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .wr_busy(wr_busy),
        .sector_pulse(sector_pulse), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .buf_grant(buf_grant), .wr_gate(wr_gate), .wr_data(wr_data)
    );

    // Synchronous buffer model and read logger.
    always @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr[7:0]];
        if (rd_clr) rd_cnt <= 0;
        else if (buf_rd_en && rd_cnt < 16) begin
            rd_log[rd_cnt] <= buf_rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int j = 0; j < 256; j++) mem[j] = seed ^ 8'(j * 29);
    endtask

    function automatic logic [31:0] ref_code();
        logic [31:0] c = 32'h0;
        for (int i = 0; i < NPAY; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[31] ^ mem[(BASE + i) % 256][b];
                c = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
            end
        return c;
    endfunction

    function automatic logic exp_bit(input int k, input logic [31:0] code);
        int p, byt, bit_i;
        logic [7:0] v;
        if (k < 2 || k >= SLEN) return 1'b0;
        p = k - 2; byt = p / 8; bit_i = 7 - (p % 8);
        if (byt < NPAY) v = mem[(BASE + byt) % 256];
        else            v = code[8 * (NTOT - 1 - byt) +: 8];
        return v[bit_i];
    endfunction

    task automatic run_vec(input logic [7:0] seed, input int gap, input logic restart);
        logic [31:0] code;
        int e_pay, e_code, e_gap, e_gate, exp_rd, rd_bad;
        fill(seed);
        code = ref_code();
        e_pay = 0; e_code = 0; e_gap = 0; e_gate = 0;
        @(negedge clk) begin rd_clr = 1'b1; cmd_start = 1'b1; end
        @(negedge clk) begin rd_clr = 1'b0; cmd_start = 1'b0; end
        check(wr_busy === 1'b1 && wr_gate === 1'b0, "R2 busy after start", wr_busy, 1);
        @(negedge clk) sector_pulse = 1'b1;
        @(negedge clk) sector_pulse = 1'b0;
        for (int k = 0; k <= gap; k++) begin
            if (wr_gate !== 1'b1 || buf_grant !== 1'b1) e_gate++;
            if (wr_data !== exp_bit(k, code)) begin
                if (k < 2 + 8 * NPAY)  e_pay++;
                else if (k < SLEN)      e_code++;
                else                    e_gap++;
            end
            cmd_start    = (restart && k == 20);
            sector_pulse = (k == gap);
            @(negedge clk);
        end
        cmd_start = 1'b0; sector_pulse = 1'b0;
        check(e_gate == 0, "R4 gate and grant held through window", e_gate, 0);
        check(e_pay == 0, "R6 lead and image bits", e_pay, 0);
        if (gap >= SLEN - 1) check(e_code == 0, "R7 check code bits", e_code, 0);
        if (gap >= SLEN) check(e_gap == 0, "R8 zero fill", e_gap, 0);
        check(wr_gate === 1'b0 && buf_grant === 1'b0, "R9 gate drops after pulse", wr_gate, 0);
        check(wr_busy === 1'b0, "R2 busy clears with gate", wr_busy, 0);
        exp_rd = 0;
        for (int i = 0; i < NPAY; i++) if (8 * i <= gap) exp_rd++;
        rd_bad = 0;
        for (int i = 0; i < exp_rd && i < 16; i++) if (rd_log[i] !== AW'(BASE + i)) rd_bad++;
        check(rd_cnt == exp_rd && rd_bad == 0, "R5 read count and addresses", rd_cnt, exp_rd);
        if (restart) begin
            @(negedge clk) sector_pulse = 1'b1;
            @(negedge clk) sector_pulse = 1'b0;
            check(wr_gate === 1'b0 && wr_busy === 1'b0, "R10 start during write not armed", wr_gate, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(wr_gate === 0 && buf_grant === 0 && wr_busy === 0, "R1 reset gate/grant/busy", wr_gate, 0);
        check(wr_data === 0 && buf_rd_en === 0, "R1 reset data/read", wr_data, 0);
        @(negedge clk) rst_n = 1'b1;
        // R3: sector pulse with nothing armed
        @(negedge clk) sector_pulse = 1'b1;
        @(negedge clk) sector_pulse = 1'b0;
        check(wr_gate === 0 && buf_grant === 0, "R3 idle pulse ignored", wr_gate, 0);
        // Vector table
        for (int v = 0; v < 5; v++)
            run_vec(VECS[v][20:13], int'(VECS[v][12:1]), VECS[v][0]);
        // R1: reset in the middle of a write
        @(negedge clk) cmd_start = 1'b1;
        @(negedge clk) begin cmd_start = 1'b0; sector_pulse = 1'b1; end
        @(negedge clk) sector_pulse = 1'b0;
        repeat (20) @(negedge clk);
        check(wr_gate === 1'b1, "R4 window open before reset", wr_gate, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(wr_gate === 0 && wr_busy === 0 && wr_data === 0, "R1 reset mid-write", wr_gate, 0);
        rst_n = 1'b1;
        @(negedge clk) sector_pulse = 1'b1;
        @(negedge clk) sector_pulse = 1'b0;
        check(wr_gate === 0, "R3 pulse after reset ignored", wr_gate, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule